// File: doc/BRIEF.md
# Dual-Image Configuration Address Sequencer

This block drives the address side of a configuration loader for a programmable device whose parallel NOR flash holds two bitstream images, one at each end of the address space. After reset, or after a qualified program request, it holds its init output low for a set number of cycles. It then samples a mode input that chooses the first image. The bottom image is read upward from address zero. The top image is read downward from the all-ones address. Words advance only when the flash side signals that data is valid, and a one-cycle done pulse marks the end of the image, whose length is a parameter.

The loaded image may arm a reload. The block captures an arm input at the moment the load completes. While an armed image runs, an active-low trigger pulse of sufficient width starts a reload of the other image from the opposite end of the flash, counting the other way. During that reload the mode input is ignored and a stored status register decides the direction. Repeated triggers alternate between the two images. A program request wipes the status, so the next load follows the mode input again. Bitstream parsing and checking are not part of the block.

Top module: `cfg_image_sequencer`

## Requirements
- R1: While reset is held, init_n, rd_en, done and status are all 0. After reset release or a program request, init_n stays low and rises on the INIT_CYCLES-th clock edge (16 by default). rd_en goes high on that same edge.
- R2: When mode_down is 0 at the start of a first load, flash_addr begins at 0 and increments by one for each accepted word (a cycle with rd_en and data_ok both 1). It holds its value in any cycle where rd_en is 1 and data_ok is 0.
- R3: When mode_down is 1 at the start of a first load, flash_addr begins at all ones and decrements by one for each accepted word.
- R4: After IMG_WORDS words (96 by default) have been accepted, done is 1 for exactly one cycle, rd_en is 0, and status bit 3 (armed) holds the value arm_in had when the last word was accepted.
- R5: A trigger pulse counts only if trig_n is sampled low on at least TRIG_MIN_NS/CLK_PERIOD_NS consecutive edges (75 by default). Shorter pulses are ignored, and the width count starts again at every falling edge. A valid pulse pulls init_n low within two cycles after trig_n returns high.
- R6: A valid trigger reloads the image at the opposite end of the flash, counting in the opposite direction, whatever the value of mode_down. The status bits then read: bit 0 = current image is the top one, bit 1 = image that was active at the trigger, bit 2 = 1 (multiboot reload), bit 3 = 0. Status does not change while a load is in progress.
- R7: A trigger pulse while status bit 3 is 0 has no effect: init_n stays high and status is unchanged.
- R8: Successive valid triggers on armed images alternate between the bottom image and the top image.
- R9: A trigger pulse that completes while a load is in progress is ignored. After the load, the block stays idle with init_n high.
- R10: prog_n sampled low on at least PROG_MIN_NS/CLK_PERIOD_NS consecutive edges (125 by default) and then released restarts the init phase. It clears status to 0, and the following load follows mode_down. A shorter pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_n | input | 1 | Active-low program request; counts only after the minimum width |
| mode_down | input | 1 | First-load select: 1 = top image downward, 0 = bottom image upward |
| trig_n | input | 1 | Active-low reload trigger |
| arm_in | input | 1 | Arm flag of the image being loaded, captured at image end |
| data_ok | input | 1 | Flash word at flash_addr is valid and accepted this cycle |
| init_n | output | 1 | Low during the init phase |
| rd_en | output | 1 | Read strobe; high while an image is loading |
| flash_addr | output | ADDR_W | Flash word address |
| done | output | 1 | One-cycle pulse at image end |
| status | output | 4 | {armed, multiboot, previous-top, current-top} |

## Verification
The assertions take for granted that every input is synchronous to clk and already free of glitches. They also take for granted that prog_n and trig_n are never released on the same edge, so the counting and status rules can be checked without arbitration corner cases. The stimulus changes every input on the falling clock edge and drives data_ok only while rd_en is high. It separates program requests from trigger pulses by at least several idle cycles. Pulse widths are set in whole cycles, one below and exactly at each threshold.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    typedef enum logic [1:0] {
        SEQ_INIT = 2'd0,
        SEQ_LOAD = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_e;

    // status word layout, msb first: armed, multiboot, previous-top, current-top
    typedef struct packed {
        logic armed;
        logic mb;
        logic prev_top;
        logic cur_top;
    } img_status_t;

endpackage

// File: rtl/cfgseq_pulse_qual.sv
module cfgseq_pulse_qual #(
    parameter int MIN_CYC = 75
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_n,
    output logic fire
);
    localparam int CW = $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0] SAT = CW'(MIN_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          low;
        logic          fire;
    } qual_t;

    qual_t q_q, q_d;

    always_comb begin
        q_d = q_q;
        if (!sig_n) begin
            q_d.low  = 1'b1;
            q_d.fire = 1'b0;
            if (q_q.cnt != SAT) begin
                q_d.cnt = q_q.cnt + CW'(1);
            end
        end else begin
            q_d.fire = q_q.low && (q_q.cnt == SAT);
            q_d.cnt  = '0;
            q_d.low  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign fire = q_q.fire;

endmodule

// File: rtl/cfgseq_addr_gen.sv
module cfgseq_addr_gen #(
    parameter int ADDR_W = 24,
    parameter int WORDS  = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              from_top,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam int CW = (WORDS > 2) ? $clog2(WORDS) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(WORDS - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CW-1:0]     idx;
        logic              down;
    } ag_t;

    ag_t q_q, q_d;

    always_comb begin
        q_d = q_q;
        if (start) begin
            q_d.addr = from_top ? '1 : '0;
            q_d.idx  = '0;
            q_d.down = from_top;
        end else if (step) begin
            q_d.addr = q_q.down ? (q_q.addr - ADDR_W'(1)) : (q_q.addr + ADDR_W'(1));
            q_d.idx  = q_q.idx + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign addr = q_q.addr;
    assign last = (q_q.idx == LAST_IDX);

endmodule

// File: rtl/cfg_image_sequencer.sv
module cfg_image_sequencer
    import cfgseq_pkg::*;
#(
    parameter int ADDR_W        = 24,
    parameter int IMG_WORDS     = 96,
    parameter int CLK_PERIOD_NS = 4,
    parameter int TRIG_MIN_NS   = 300,
    parameter int PROG_MIN_NS   = 500,
    parameter int INIT_CYCLES   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_n,
    input  logic              mode_down,
    input  logic              trig_n,
    input  logic              arm_in,
    input  logic              data_ok,
    output logic              init_n,
    output logic              rd_en,
    output logic [ADDR_W-1:0] flash_addr,
    output logic              done,
    output logic [3:0]        status
);
    localparam int TRIG_CYC = (TRIG_MIN_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int PROG_CYC = (PROG_MIN_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int IW       = (INIT_CYCLES > 2) ? $clog2(INIT_CYCLES) : 1;
    localparam logic [IW-1:0] INIT_LAST = IW'(INIT_CYCLES - 1);

    typedef struct packed {
        seq_state_e  state;
        logic [IW-1:0] init_cnt;
        img_status_t st;
        logic        done;
    } seq_t;

    seq_t q_q, q_d;

    logic trig_fire, prog_fire;
    logic ag_start, ag_step, ag_last, load_top;

    cfgseq_pulse_qual #(.MIN_CYC(TRIG_CYC)) u_trig_qual (
        .clk  (clk),
        .rst_n(rst_n),
        .sig_n(trig_n),
        .fire (trig_fire)
    );

    cfgseq_pulse_qual #(.MIN_CYC(PROG_CYC)) u_prog_qual (
        .clk  (clk),
        .rst_n(rst_n),
        .sig_n(prog_n),
        .fire (prog_fire)
    );

    cfgseq_addr_gen #(.ADDR_W(ADDR_W), .WORDS(IMG_WORDS)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (ag_start),
        .from_top(load_top),
        .step    (ag_step),
        .addr    (flash_addr),
        .last    (ag_last)
    );

    always_comb begin
        q_d      = q_q;
        q_d.done = 1'b0;
        ag_start = 1'b0;
        ag_step  = 1'b0;
        // a multiboot reload follows the stored image, a first load the mode pin
        load_top = q_q.st.mb ? q_q.st.cur_top : mode_down;
        if (prog_fire) begin
            q_d.state    = SEQ_INIT;
            q_d.init_cnt = '0;
            q_d.st       = '0;
        end else begin
            unique case (q_q.state)
                SEQ_INIT: begin
                    if (q_q.init_cnt == INIT_LAST) begin
                        ag_start       = 1'b1;
                        q_d.state      = SEQ_LOAD;
                        q_d.st.cur_top = load_top;
                    end else begin
                        q_d.init_cnt = q_q.init_cnt + IW'(1);
                    end
                end
                SEQ_LOAD: begin
                    if (data_ok) begin
                        ag_step = 1'b1;
                        if (ag_last) begin
                            q_d.done     = 1'b1;
                            q_d.state    = SEQ_RUN;
                            q_d.st.armed = arm_in;
                        end
                    end
                end
                SEQ_RUN: begin
                    if (trig_fire && q_q.st.armed) begin
                        q_d.state       = SEQ_INIT;
                        q_d.init_cnt    = '0;
                        q_d.st.mb       = 1'b1;
                        q_d.st.prev_top = q_q.st.cur_top;
                        q_d.st.cur_top  = ~q_q.st.cur_top;
                        q_d.st.armed    = 1'b0;
                    end
                end
                default: begin
                    q_d.state = SEQ_INIT;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '{state: SEQ_INIT, init_cnt: '0, st: '0, done: 1'b0};
        end else begin
            q_q <= q_d;
        end
    end

    assign init_n = (q_q.state != SEQ_INIT);
    assign rd_en  = (q_q.state == SEQ_LOAD);
    assign done   = q_q.done;
    assign status = q_q.st;

endmodule

// File: rtl/cfgseq_checker.sv
module cfgseq_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              init_n,
    input logic              rd_en,
    input logic              data_ok,
    input logic              done,
    input logic [ADDR_W-1:0] flash_addr,
    input logic [3:0]        status
);

    p_read_after_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> init_n);

    // R2 and R3: the first read address sits at the end chosen for the image
    p_start_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en) |-> (flash_addr == (status[0] ? {ADDR_W{1'b1}} : {ADDR_W{1'b0}})));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && data_ok) |=> (!rd_en ||
            (flash_addr == (status[0] ? ADDR_W'($past(flash_addr) - ADDR_W'(1))
                                      : ADDR_W'($past(flash_addr) + ADDR_W'(1))))));

    p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !data_ok) |=> $stable(flash_addr));

    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_ends_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_en);

    p_status_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en ##1 rd_en) |-> $stable(status));

    p_image_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status[0]) |-> (!init_n || !$past(init_n)));

endmodule

bind cfg_image_sequencer cfgseq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_n    (init_n),
    .rd_en     (rd_en),
    .data_ok   (data_ok),
    .done      (done),
    .flash_addr(flash_addr),
    .status    (status)
);

// File: tb/sim_cfg_image_sequencer.sv
module sim_cfg_image_sequencer;
    localparam int AW    = 24;
    localparam int WORDS = 96;
    localparam int INITC = 16;
    localparam int TCYC  = 75;
    localparam int PCYC  = 125;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_n = 1'b1;
    logic mode_down = 1'b0;
    logic trig_n = 1'b1;
    logic arm_in = 1'b0;
    logic data_ok = 1'b0;
    logic init_n, rd_en, done;
    logic [AW-1:0] flash_addr;
    logic [3:0] status;

    int total = 0;
    int fails = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    cfg_image_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .mode_down(mode_down),
        .trig_n(trig_n), .arm_in(arm_in), .data_ok(data_ok), .init_n(init_n),
        .rd_en(rd_en), .flash_addr(flash_addr), .done(done), .status(status)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                chk(1'b0, "watchdog", 32'(cycles), 32'd150000);
                finish_run();
            end
        end
    end

    // called on a falling edge while init_n is low or has just risen
    task automatic run_load(input logic top, input logic arm, input string req);
        int idx = 0;
        int cyc = 0;
        int err = 0;
        logic [AW-1:0] exp_a;
        logic [AW-1:0] first_a;
        arm_in = arm;
        while (!init_n) @(negedge clk);
        first_a = flash_addr;
        while (idx < WORDS) begin
            exp_a = top ? ({AW{1'b1}} - AW'(idx)) : AW'(idx);
            if (!rd_en || flash_addr !== exp_a) err++;
            data_ok = ((cyc % 4) != 1);
            if (data_ok) idx++;
            cyc++;
            @(negedge clk);
        end
        data_ok = 1'b0;
        chk(first_a == (top ? {AW{1'b1}} : {AW{1'b0}}), req, 32'(first_a), top ? 32'hFFFFFF : 32'h0);
        chk(err == 0, req, 32'(err), 32'd0);
        chk(done && !rd_en, "R4", {30'd0, done, rd_en}, 32'h2);
        chk(status[3] == arm, "R4", 32'(status[3]), 32'(arm));
        @(negedge clk);
        chk(!done, "R4", 32'(done), 32'd0);
    endtask

    task automatic pulse_trig(input int n);
        trig_n = 1'b0;
        repeat (n) @(negedge clk);
        trig_n = 1'b1;
    endtask

    task automatic pulse_prog(input int n);
        prog_n = 1'b0;
        repeat (n) @(negedge clk);
        prog_n = 1'b1;
    endtask

    // trigger that must be ignored: init_n stays high, status unchanged
    task automatic expect_ignored(input string req, input logic [3:0] exp_st);
        repeat (4) @(negedge clk);
        chk(init_n == 1'b1, req, 32'(init_n), 32'd1);
        chk(status == exp_st, req, 32'(status), 32'(exp_st));
    endtask

    task automatic t_reset();
        int lows = 0;
        repeat (3) @(negedge clk);
        chk({init_n, rd_en, done, status} == 7'd0, "R1", 32'({init_n, rd_en, done, status}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        while (!init_n && lows < 100) begin
            lows++;
            @(negedge clk);
        end
        chk(lows == INITC - 1, "R1", 32'(lows), 32'(INITC - 1));
        chk(rd_en == 1'b1, "R1", 32'(rd_en), 32'd1);
    endtask

    task automatic t_trigger_filter();
        pulse_trig(TCYC - 1);
        expect_ignored("R5", 4'b1000);
        pulse_trig(50);
        @(negedge clk);
        pulse_trig(50);
        expect_ignored("R5", 4'b1000);
    endtask

    task automatic t_multiboot(input logic old_top, input int width, input string req);
        logic [3:0] exp_st;
        exp_st = {1'b0, 1'b1, old_top, ~old_top};
        pulse_trig(width);
        repeat (2) @(negedge clk);
        chk(init_n == 1'b0, req, 32'(init_n), 32'd0);
        chk(status == exp_st, req, 32'(status), 32'(exp_st));
    endtask

    task automatic t_prog(input logic expect_mode);
        pulse_prog(PCYC - 1);
        expect_ignored("R10", status);
        mode_down = expect_mode;
        pulse_prog(PCYC);
        repeat (2) @(negedge clk);
        chk(init_n == 1'b0, "R10", 32'(init_n), 32'd0);
        chk(status == 4'b0000, "R10", 32'(status), 32'd0);
    endtask

    initial begin
        t_reset();
        run_load(1'b0, 1'b1, "R2");
        chk(status == 4'b1000, "R2", 32'(status), 32'h8);
        t_trigger_filter();
        // mode pin says bottom; the reload must still take the top (R6)
        mode_down = 1'b0;
        t_multiboot(1'b0, TCYC, "R5");
        run_load(1'b1, 1'b0, "R6");
        chk(status == 4'b0101, "R6", 32'(status), 32'h5);
        pulse_trig(100);
        expect_ignored("R7", 4'b0101);
        t_prog(1'b1);
        run_load(1'b1, 1'b1, "R3");
        chk(status == 4'b1001, "R10", 32'(status), 32'h9);
        // R9: pulse completes while the next image is loading
        t_multiboot(1'b1, TCYC + 5, "R8");
        fork
            run_load(1'b0, 1'b1, "R8");
            begin
                repeat (5) @(negedge clk);
                pulse_trig(80);
            end
        join
        expect_ignored("R9", 4'b1110);
        t_multiboot(1'b0, TCYC, "R8");
        run_load(1'b1, 1'b0, "R8");
        chk(status == 4'b0101, "R8", 32'(status), 32'h5);
        finish_run();
    end

endmodule